// File: doc/BRIEF.md
# Multicycle Five-Instruction Integer Datapath

This block is the datapath half of a small multicycle processor. An instruction is spread over several clock cycles, and each cycle latches its result into an internal holding register. The holding registers are the program counter, the instruction word, two operand registers, the ALU result, the memory data register and a one-bit equality flag. An external sequencer owns all control. It raises one load strobe per holding register and sets the mux selects. It reads back the opcode, the function field and the equality flag to choose its next step. The datapath has no control logic of its own.

The supported work covers register-register add, subtract, AND and OR, OR with an immediate, word load, word store and branch-if-equal. The register file holds `NREG` words of `XLEN` bits and has two read ports and one write port. The datapath presents the program counter as the instruction-memory address. It presents the ALU result register as the data-memory address and the second operand register as the data to store.

Top module: `mcd_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, instruction register, operand registers, result register, memory data register and equality flag are all cleared. Afterwards `imem_addr`, `opcode`, `funct`, `eq_flag`, `dmem_addr` and `dmem_wdata` read zero.
- R2: With `ld_inst` high at an edge, the instruction register takes `imem_rdata`. `opcode` then shows instruction bits 31:26 and `funct` shows bits 5:0.
- R3: With `ld_opa`, `ld_opb` and `ld_eq` high at an edge, the two operand registers take the register-file words selected by instruction bits 25:21 (first operand) and 20:16 (second operand). The equality flag takes 1 if those two words are equal and 0 otherwise.
- R4: With `ld_res` high at an edge, the result register takes the ALU output and drives `dmem_addr`. The first ALU input is the first operand. `opb_src` selects the second input: 00 or 11 the second operand, 01 instruction bits 15:0 sign-extended, 10 the same bits zero-extended. `alu_mode` selects the operation: 00 add, 01 subtract (first minus second), 10 OR, 11 decode `funct`. In the `funct` decode, 0x23 subtracts, 0x24 ANDs, 0x25 ORs and every other value adds.
- R5: `dmem_wdata` always shows the second operand register.
- R6: With `ld_mdr` high at an edge, the memory data register takes `dmem_rdata`. When `ld_mdr` is low, that register keeps its value whatever `dmem_rdata` does.
- R7: With `rf_wr` high at an edge, a register is written. It is the one named by instruction bits 15:11 when `wr_dst_rd` is 1, or by bits 20:16 when it is 0. The value written is the memory data register when `wr_from_mem` is 1, otherwise the result register.
- R8: Register 0 always reads as zero, and writes addressed to it have no effect.
- R9: With `ld_pc` high and `pc_cond_br` low at an edge, the program counter advances by 4.
- R10: With `ld_pc` and `pc_cond_br` both high at an edge, the program counter advances by 4 if the equality flag is 0. If the flag is 1, it becomes PC + 4 plus the sign-extended bits 15:0 shifted left by two.
- R11: Every holding register keeps its value at any edge where its own load strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_pc | input | 1 | Load program counter |
| pc_cond_br | input | 1 | Program counter update is a conditional branch |
| ld_inst | input | 1 | Load instruction register |
| ld_opa | input | 1 | Load first operand register |
| ld_opb | input | 1 | Load second operand register |
| ld_eq | input | 1 | Load equality flag |
| ld_res | input | 1 | Load ALU result register |
| ld_mdr | input | 1 | Load memory data register |
| alu_mode | input | 2 | ALU operation select |
| opb_src | input | 2 | Second ALU input select |
| rf_wr | input | 1 | Register-file write enable |
| wr_dst_rd | input | 1 | Write address from bits 15:11 (1) or 20:16 (0) |
| wr_from_mem | input | 1 | Write data from memory data register (1) or result register (0) |
| imem_addr | output | XLEN | Instruction fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word read from memory |
| dmem_addr | output | XLEN | Data memory address (result register) |
| dmem_wdata | output | XLEN | Data memory store data (second operand register) |
| dmem_rdata | input | XLEN | Data word read from memory |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| eq_flag | output | 1 | Equality flag |

## Verification
The register file has no read port of its own, so its contents can only be seen indirectly. A value that was written reaches the pins only when a later instruction moves it through an operand register onto `dmem_wdata` or through the ALU onto `dmem_addr`. The stimulus therefore runs a short program. Immediate ORs build known values, register-register operations combine them, and stores expose them. A store of register 0 after an attempted write to it checks that register 0 stays zero. A write-back from the memory data register after `dmem_rdata` has changed shows that the register ignored the unstrobed input.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   // ALU operation select (port alu_mode)
   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_OR  = 2'b10,
      ALU_FN  = 2'b11
   } alu_mode_e;

   // second ALU input select (port opb_src)
   typedef enum logic [1:0] {
      OPB_REG  = 2'b00,
      OPB_SEXT = 2'b01,
      OPB_ZEXT = 2'b10,
      OPB_REGX = 2'b11
   } opb_src_e;

   // function-field codes honoured when alu_mode selects the funct decode
   localparam logic [5:0] FN_SUB = 6'h23;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;

   // instruction word geometry
   localparam int unsigned INST_W    = 32;
   localparam int unsigned IMM_W     = 16;
   localparam int unsigned RIDX_W    = 5;
   localparam int unsigned INST_BYTES = 4;

endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
   parameter int unsigned W    = 32,
   parameter int unsigned NREG = 32,
   parameter int unsigned IW   = 5
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [IW-1:0] raddr0,
   input  logic [IW-1:0] raddr1,
   output logic [W-1:0]  rdata0,
   output logic [W-1:0]  rdata1
);

   localparam int unsigned AW = (NREG > 1) ? $clog2(NREG) : 1;

   logic [W-1:0] ent [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      if (i == 0) begin : g_zero
         assign ent[i] = '0;
      end else begin : g_reg
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (we && (int'(waddr) == i)) begin
               q <= wdata;
            end
         end
         assign ent[i] = q;
      end
   end

   logic [AW-1:0] ridx0, ridx1;
   assign ridx0 = AW'(raddr0);
   assign ridx1 = AW'(raddr1);

   assign rdata0 = (int'(raddr0) < NREG) ? ent[ridx0] : '0;
   assign rdata1 = (int'(raddr1) < NREG) ? ent[ridx1] : '0;

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
   import mcd_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   mode,
   input  logic [5:0]   fn,
   output logic [W-1:0] y
);

   typedef enum logic [1:0] {K_ADD, K_SUB, K_AND, K_OR} kind_e;

   kind_e kind;

   always_comb begin
      unique case (alu_mode_e'(mode))
         ALU_ADD: kind = K_ADD;
         ALU_SUB: kind = K_SUB;
         ALU_OR:  kind = K_OR;
         default: begin
            case (fn)
               FN_SUB:  kind = K_SUB;
               FN_AND:  kind = K_AND;
               FN_OR:   kind = K_OR;
               default: kind = K_ADD;
            endcase
         end
      endcase
   end

   always_comb begin
      unique case (kind)
         K_ADD:   y = a + b;
         K_SUB:   y = a - b;
         K_AND:   y = a & b;
         default: y = a | b;
      endcase
   end

endmodule

// File: rtl/mcd_pc_next.sv
module mcd_pc_next
   import mcd_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0]     pc,
   input  logic [IMM_W-1:0] imm,
   input  logic             cond_br,
   input  logic             eq,
   output logic [W-1:0]     nxt
);

   localparam logic [W-1:0] STEP = W'(INST_BYTES);

   logic [W-1:0] seq_pc;
   logic [W-1:0] offs;
   logic [W-1:0] tgt_pc;

   assign seq_pc = pc + STEP;
   assign offs   = {{(W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
   assign tgt_pc = seq_pc + offs;
   assign nxt    = (cond_br && eq) ? tgt_pc : seq_pc;

endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
   import mcd_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NREG = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ld_pc,
   input  logic            pc_cond_br,
   input  logic            ld_inst,
   input  logic            ld_opa,
   input  logic            ld_opb,
   input  logic            ld_eq,
   input  logic            ld_res,
   input  logic            ld_mdr,
   input  logic [1:0]      alu_mode,
   input  logic [1:0]      opb_src,
   input  logic            rf_wr,
   input  logic            wr_dst_rd,
   input  logic            wr_from_mem,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic [5:0]      opcode,
   output logic [5:0]      funct,
   output logic            eq_flag
);

   if (XLEN < 32) begin : g_bad_xlen
      $error("mcd_datapath: XLEN must be at least 32");
   end
   if (NREG < 2 || NREG > 32) begin : g_bad_nreg
      $error("mcd_datapath: NREG must lie in 2..32");
   end

   // holding registers
   logic [XLEN-1:0]   pc_q, opa_q, opb_q, res_q, mdr_q;
   logic [INST_W-1:0] inst_q;
   logic              eq_q;

   // instruction fields
   logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
   logic [IMM_W-1:0]  f_imm;
   assign f_rs  = inst_q[25:21];
   assign f_rt  = inst_q[20:16];
   assign f_rd  = inst_q[15:11];
   assign f_imm = inst_q[15:0];

   // register file
   logic [XLEN-1:0]   rs_val, rt_val, wr_val;
   logic [RIDX_W-1:0] wr_idx;

   assign wr_idx = wr_dst_rd   ? f_rd  : f_rt;
   assign wr_val = wr_from_mem ? mdr_q : res_q;

   mcd_regfile #(
      .W    (XLEN),
      .NREG (NREG),
      .IW   (RIDX_W)
   ) u_rf (
      .clk    (clk),
      .we     (rf_wr),
      .waddr  (wr_idx),
      .wdata  (wr_val),
      .raddr0 (f_rs),
      .raddr1 (f_rt),
      .rdata0 (rs_val),
      .rdata1 (rt_val)
   );

   // dedicated equality comparator
   logic eq_nxt;
   assign eq_nxt = (rs_val == rt_val);

   // second ALU input
   logic [XLEN-1:0] imm_sx, imm_zx, alu_b, alu_y;
   assign imm_sx = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
   assign imm_zx = {{(XLEN-IMM_W){1'b0}}, f_imm};

   always_comb begin
      unique case (opb_src_e'(opb_src))
         OPB_SEXT: alu_b = imm_sx;
         OPB_ZEXT: alu_b = imm_zx;
         default:  alu_b = opb_q;
      endcase
   end

   mcd_alu #(
      .W (XLEN)
   ) u_alu (
      .a    (opa_q),
      .b    (alu_b),
      .mode (alu_mode),
      .fn   (inst_q[5:0]),
      .y    (alu_y)
   );

   // next program counter
   logic [XLEN-1:0] pc_nxt;

   mcd_pc_next #(
      .W (XLEN)
   ) u_pcn (
      .pc      (pc_q),
      .imm     (f_imm),
      .cond_br (pc_cond_br),
      .eq      (eq_q),
      .nxt     (pc_nxt)
   );

   // register transfers, one strobe each
   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
      end else if (ld_pc) begin
         pc_q <= pc_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         inst_q <= '0;
      end else if (ld_inst) begin
         inst_q <= imem_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         opa_q <= '0;
      end else if (ld_opa) begin
         opa_q <= rs_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         opb_q <= '0;
      end else if (ld_opb) begin
         opb_q <= rt_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         eq_q <= 1'b0;
      end else if (ld_eq) begin
         eq_q <= eq_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
      end else if (ld_res) begin
         res_q <= alu_y;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mdr_q <= '0;
      end else if (ld_mdr) begin
         mdr_q <= dmem_rdata;
      end
   end

   // outputs
   assign imem_addr  = pc_q;
   assign dmem_addr  = res_q;
   assign dmem_wdata = opb_q;
   assign opcode     = inst_q[31:26];
   assign funct      = inst_q[5:0];
   assign eq_flag    = eq_q;

endmodule

// File: rtl/mcd_datapath_chk.sv
module mcd_datapath_chk #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            ld_pc,
   input logic            pc_cond_br,
   input logic            ld_inst,
   input logic            ld_opb,
   input logic            ld_eq,
   input logic            ld_res,
   input logic [31:0]     imem_rdata,
   input logic [XLEN-1:0] imem_addr,
   input logic [XLEN-1:0] dmem_addr,
   input logic [XLEN-1:0] dmem_wdata,
   input logic [5:0]      opcode,
   input logic [5:0]      funct,
   input logic            eq_flag
);

   p_inst_load_r2: assert property (@(posedge clk) disable iff (rst)
      ld_inst |=> (opcode == $past(imem_rdata[31:26])) && (funct == $past(imem_rdata[5:0])));

   p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
      (ld_pc && !pc_cond_br) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

   p_br_not_taken_r10: assert property (@(posedge clk) disable iff (rst)
      (ld_pc && pc_cond_br && !eq_flag) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

   p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !ld_pc |=> $stable(imem_addr));

   p_inst_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !ld_inst |=> ($stable(opcode) && $stable(funct)));

   p_res_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !ld_res |=> $stable(dmem_addr));

   p_opb_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !ld_opb |=> $stable(dmem_wdata));

   p_eq_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !ld_eq |=> $stable(eq_flag));

endmodule

bind mcd_datapath mcd_datapath_chk #(.XLEN(XLEN)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ld_pc      (ld_pc),
   .pc_cond_br (pc_cond_br),
   .ld_inst    (ld_inst),
   .ld_opb     (ld_opb),
   .ld_eq      (ld_eq),
   .ld_res     (ld_res),
   .imem_rdata (imem_rdata),
   .imem_addr  (imem_addr),
   .dmem_addr  (dmem_addr),
   .dmem_wdata (dmem_wdata),
   .opcode     (opcode),
   .funct      (funct),
   .eq_flag    (eq_flag)
);

// File: tb/mcd_datapath_test.sv
module mcd_datapath_test;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 32;

   logic            clk = 1'b0;
   logic            rst;
   logic            ld_pc, pc_cond_br, ld_inst, ld_opa, ld_opb, ld_eq, ld_res, ld_mdr;
   logic [1:0]      alu_mode, opb_src;
   logic            rf_wr, wr_dst_rd, wr_from_mem;
   logic [XLEN-1:0] imem_addr;
   logic [31:0]     imem_rdata;
   logic [XLEN-1:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic [5:0]      opcode, funct;
   logic            eq_flag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcd_datapath #(.XLEN(XLEN), .NREG(32)) uut (
      .clk (clk), .rst (rst),
      .ld_pc (ld_pc), .pc_cond_br (pc_cond_br), .ld_inst (ld_inst),
      .ld_opa (ld_opa), .ld_opb (ld_opb), .ld_eq (ld_eq),
      .ld_res (ld_res), .ld_mdr (ld_mdr),
      .alu_mode (alu_mode), .opb_src (opb_src),
      .rf_wr (rf_wr), .wr_dst_rd (wr_dst_rd), .wr_from_mem (wr_from_mem),
      .imem_addr (imem_addr), .imem_rdata (imem_rdata),
      .dmem_addr (dmem_addr), .dmem_wdata (dmem_wdata), .dmem_rdata (dmem_rdata),
      .opcode (opcode), .funct (funct), .eq_flag (eq_flag)
   );

   typedef struct packed {
      logic [31:0] ins;
      logic [31:0] mrd;
      logic [31:0] exp_s;
      logic [31:0] exp_wd;
      logic [31:0] exp_pc;
   } vec_t;

   // exp_s holds the expected result register, or for a branch the expected flag
   localparam int NVEC = 16;
   localparam vec_t TBL [NVEC] = '{
      '{32'h34011234, 32'h0,        32'h00001234, 32'h0,        32'd4},
      '{32'h3402FFFF, 32'h0,        32'h0000FFFF, 32'h0,        32'd8},
      '{32'h00221821, 32'h0,        32'h00011233, 32'h0,        32'd12},
      '{32'h00222023, 32'h0,        32'hFFFF1235, 32'h0,        32'd16},
      '{32'h00412824, 32'h0,        32'h00001234, 32'h0,        32'd20},
      '{32'hAC230008, 32'h0,        32'h0000123C, 32'h00011233, 32'd24},
      '{32'h8C26FFFC, 32'hDEADBEEF, 32'h00001230, 32'h0,        32'd28},
      '{32'hAC060000, 32'h0,        32'h00000000, 32'hDEADBEEF, 32'd32},
      '{32'h34000005, 32'h0,        32'h00000005, 32'h0,        32'd36},
      '{32'hAC000004, 32'h0,        32'h00000004, 32'h00000000, 32'd40},
      '{32'h10210003, 32'h0,        32'h00000001, 32'h0,        32'd56},
      '{32'h1022FFFE, 32'h0,        32'h00000000, 32'h0,        32'd60},
      '{32'h1063FFFB, 32'h0,        32'h00000001, 32'h0,        32'd44},
      '{32'h00823825, 32'h0,        32'hFFFFFFFF, 32'h0,        32'd48},
      '{32'hAC470000, 32'h0,        32'h0000FFFF, 32'hFFFFFFFF, 32'd52},
      '{32'hAC050000, 32'h0,        32'h00000000, 32'h00001234, 32'd56}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_ctrl();
      ld_pc = 0; pc_cond_br = 0; ld_inst = 0; ld_opa = 0; ld_opb = 0;
      ld_eq = 0; ld_res = 0; ld_mdr = 0; alu_mode = 2'b00; opb_src = 2'b00;
      rf_wr = 0; wr_dst_rd = 0; wr_from_mem = 0;
   endtask

   // inputs are set at a falling edge; tick crosses one rising edge and returns at the next falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      clear_ctrl();
   endtask

   task automatic fetch_decode(input logic [31:0] ins);
      imem_rdata = ins; ld_inst = 1; tick();
      ld_opa = 1; ld_opb = 1; ld_eq = 1; tick();
   endtask

   task automatic run_vec(input vec_t v);
      logic [5:0] op;
      op = v.ins[31:26];
      imem_rdata = v.ins; ld_inst = 1; tick();
      check("R2 opcode", {26'b0, opcode}, {26'b0, op});
      check("R2 funct", {26'b0, funct}, {26'b0, v.ins[5:0]});
      ld_opa = 1; ld_opb = 1; ld_eq = 1; tick();
      case (op)
         6'h00: begin
            alu_mode = 2'b11; opb_src = 2'b00; ld_res = 1; tick();
            check("R4 R7 funct result", dmem_addr, v.exp_s);
            rf_wr = 1; wr_dst_rd = 1; ld_pc = 1; tick();
         end
         6'h0D: begin
            alu_mode = 2'b10; opb_src = 2'b10; ld_res = 1; tick();
            check("R4 R8 or-immediate result", dmem_addr, v.exp_s);
            rf_wr = 1; ld_pc = 1; tick();
         end
         6'h23: begin
            ld_res = 1; opb_src = 2'b01; tick();
            check("R4 load address", dmem_addr, v.exp_s);
            dmem_rdata = v.mrd; ld_mdr = 1; tick();
            rf_wr = 1; wr_from_mem = 1; ld_pc = 1; tick();
         end
         6'h2B: begin
            ld_res = 1; opb_src = 2'b01; tick();
            check("R4 store address", dmem_addr, v.exp_s);
            check("R5 R6 R8 store data", dmem_wdata, v.exp_wd);
            ld_pc = 1; tick();
         end
         default: begin
            check("R3 equality flag", {31'b0, eq_flag}, v.exp_s);
            ld_pc = 1; pc_cond_br = 1; tick();
         end
      endcase
      check("R9 R10 program counter", imem_addr, v.exp_pc);
   endtask

   task automatic check_reset_state(input string tag);
      check(tag, imem_addr, 32'h0);
      check(tag, {20'b0, opcode, funct}, 32'h0);
      check(tag, {31'b0, eq_flag}, 32'h0);
      check(tag, dmem_addr, 32'h0);
      check(tag, dmem_wdata, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      clear_ctrl();
      rst = 1'b1;
      imem_rdata = 32'h0;
      dmem_rdata = 32'h0;
      @(negedge clk);
      tick();
      tick();
      rst = 1'b0;
      check_reset_state("R1 reset state");

      // table-driven program
      for (int i = 0; i < NVEC; i++) begin
         run_vec(TBL[i]);
      end

      // R4: explicit subtract, sign- and zero-extended immediates
      fetch_decode(32'h00208000);           // first operand r1 = 0x1234, imm 0x8000
      alu_mode = 2'b01; opb_src = 2'b00; ld_res = 1; tick();
      check("R4 subtract r1-r0", dmem_addr, 32'h00001234);
      alu_mode = 2'b00; opb_src = 2'b01; ld_res = 1; tick();
      check("R4 sign-extended add", dmem_addr, 32'hFFFF9234);
      alu_mode = 2'b00; opb_src = 2'b10; ld_res = 1; tick();
      check("R4 zero-extended add", dmem_addr, 32'h00009234);
      fetch_decode(32'h00220000);           // r1 and r2
      alu_mode = 2'b01; opb_src = 2'b00; ld_res = 1; tick();
      check("R4 explicit subtract", dmem_addr, 32'hFFFF1235);

      // R11: nothing moves while all strobes are low
      imem_rdata = 32'hFFFFFFFF;
      dmem_rdata = 32'h55555555;
      tick();
      tick();
      check("R11 pc hold", imem_addr, 32'd56);
      check("R11 inst hold", {20'b0, opcode, funct}, 32'h0);
      check("R11 result hold", dmem_addr, 32'hFFFF1235);
      check("R11 flag hold", {31'b0, eq_flag}, 32'h0);

      // R6: memory data register ignored the new dmem_rdata; write it to r8 and store it
      fetch_decode(32'h00080000);
      rf_wr = 1; wr_from_mem = 1; tick();
      fetch_decode(32'hAC080000);
      check("R6 memory data held", dmem_wdata, 32'hDEADBEEF);

      // R10 taken branch forward from PC 56: beq r2,r2,+1 -> 64
      fetch_decode(32'h10420001);
      check("R3 equal flag set", {31'b0, eq_flag}, 32'h1);
      ld_pc = 1; pc_cond_br = 1; tick();
      check("R10 taken branch", imem_addr, 32'd64);

      // R1: reset in the middle of operation
      rst = 1'b1; tick();
      rst = 1'b0;
      check_reset_state("R1 reset mid-run");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule